// File: doc/BRIEF.md
# Shared-Memory Cell Sub-switch

This block is an S-by-S cell switch element in which a single shared cell memory does the switching. There is no crossbar. An arriving cell is written once into the shared memory, at an address drawn from a pool of free addresses. That address is then appended to the pointer queue of every output named in the cell's destination mask. Each output reads its cells back by address, so the address selection of the memory forms the switch path.

Inputs are admitted by a fixed rotating time slot: in each cycle one input may write. Outputs are served by one memory read per cycle, and the read slot rotates round-robin among outputs whose pointer queues hold work. The pool is shared by all outputs, so a congested output can occupy far more than its 1/S share of the buffer. A multicast cell occupies one location. A per-location reference count releases the location after its last reader, and the address then passes through a one-register recycle stage on its way back to the pool. The pool memory is loaded with every address during a start-up phase after reset.

Top module: `shared_cell_switch`

## Requirements
- R1: After reset is released, in_ready and out_valid stay all-zero while the pool loads. in_ready first becomes non-zero after exactly NCELL rising edges, and it then shows input 0.
- R2: At most one bit of in_ready is set in any cycle. When not stalled, the admitting input advances 0, 1, ..., S-1, 0 by one each cycle, and a cell is taken only from the input whose in_ready bit is set.
- R3: A cell accepted on a rising edge with in_valid and in_ready both high appears later on every output o whose destination bit o is set, with out_valid[o] high and an unchanged DW-bit word on slice o of out_data. No cell appears that was not sent.
- R4: Cells bound for one output leave that output in the order in which they were accepted, whichever inputs they came from.
- R5: Bit o of an input's destination mask selects output o. A cell whose mask has k bits set is delivered exactly once on each of those k outputs.
- R6: At most one bit of out_valid is set in any cycle, because one cell is read per cycle.
- R7: Output service is round-robin. After output o is served, the next read goes to the first non-empty pointer queue after o, in the cyclic order o+1, o+2, and so on. When every queue holds work, reads step o, o+1 mod S.
- R8: in_ready is all-zero while the free pool is empty or any pointer queue is full. Under sustained multicast load this stall occurs, and no cell is lost or duplicated.
- R9: A buffer location is returned to the pool only after its last destination has read it, through one recycle register. Traffic totalling many times NCELL cells therefore completes without exhausting the pool.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-input cell present |
| in_data | input | NPORT*DW | Per-input cell word; slice i belongs to input i |
| in_dest | input | NPORT*NPORT | Per-input destination mask; slice i is input i's mask, bit o selects output o |
| in_ready | output | NPORT | Per-input admission; a cell is taken when valid and ready meet at an edge |
| out_valid | output | NPORT | Per-output cell present this cycle (registered) |
| out_data | output | NPORT*DW | Per-output cell word; slice o is meaningful while out_valid[o] is high |

## Verification
The assertions assume that every offered cell carries a non-zero destination mask and that the mask stays put while the cell waits for its slot. A zero mask would consume an address that no reader ever frees. The stimulus draws every mask from the range 1 to 2^S-1 and holds data and mask constant from the moment valid rises until the cell is taken. Outputs have no backpressure, so queue-full stalls are provoked only by fanning broadcast cells out faster than the single read port drains them.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

  // cyclic successor of v within 0..n-1
  function automatic int wrap_next(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // index that lies k steps after base in cyclic order of n
  function automatic int wrap_add(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction

endpackage

// File: rtl/ssw_addr_fifo.sv
module ssw_addr_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= PW'(ssw_pkg::wrap_next(int'(wp), DEPTH));
      if (pop)  rp <= PW'(ssw_pkg::wrap_next(int'(rp), DEPTH));
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R8: the producer never writes into a full queue or pool
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R9: the consumer never takes from an empty queue or pool
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/ssw_rr_arb.sv
module ssw_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);

  logic [IW-1:0] last;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[ssw_pkg::wrap_add(int'(last), k, N)]) begin
        any     = 1'b1;
        gnt_idx = IW'(ssw_pkg::wrap_add(int'(last), k, N));
        gnt[ssw_pkg::wrap_add(int'(last), k, N)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      last <= IW'(N - 1);
    else if (any) last <= gnt_idx;
  end

  // R7: with every requester active, the grant steps by one
  p_rr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (any && $past(any) && (&req) && $past(&req) && !$past(rst))
      |-> (int'(gnt_idx) == ssw_pkg::wrap_next(int'($past(gnt_idx)), N)));

  p_grant_single_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

endmodule

// File: rtl/ssw_cell_ram.sv
module ssw_cell_ram #(
  parameter int DW    = 256,
  parameter int NCELL = 16,
  localparam int AW   = $clog2(NCELL)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NCELL];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/shared_cell_switch.sv
module shared_cell_switch #(
  parameter int NPORT  = 4,
  parameter int DW     = 256,
  parameter int NCELL  = 16,
  parameter int QDEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT*DW-1:0]    in_data,
  input  logic [NPORT*NPORT-1:0] in_dest,
  output logic [NPORT-1:0]       in_ready,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*DW-1:0]    out_data
);

  localparam int AW  = $clog2(NCELL);
  localparam int SW  = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int FCW = $clog2(NCELL + 1);
  localparam int RCW = $clog2(NPORT + 1);

  // unpacked views of the input bundles
  logic [DW-1:0]    din_a [NPORT];
  logic [NPORT-1:0] dst_a [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_unpack
    assign din_a[i] = in_data[i*DW +: DW];
    assign dst_a[i] = in_dest[i*NPORT +: NPORT];
  end

  // start-up load of the free pool
  logic [FCW-1:0] fill_cnt;
  logic           filling;
  assign filling = (fill_cnt != FCW'(NCELL));

  always_ff @(posedge clk) begin
    if (rst)          fill_cnt <= '0;
    else if (filling) fill_cnt <= fill_cnt + 1'b1;
  end

  // admission slot rotation
  logic [SW-1:0] slot;
  always_ff @(posedge clk) begin
    if (rst)           slot <= '0;
    else if (!filling) slot <= SW'(ssw_pkg::wrap_next(int'(slot), NPORT));
  end

  // recycle stage
  logic          rec_valid;
  logic [AW-1:0] rec_addr;

  // free address pool
  logic          pool_push, pool_empty, pool_full, accept;
  logic [AW-1:0] pool_din, pool_dout;

  assign pool_push = filling | rec_valid;
  assign pool_din  = filling ? AW'(fill_cnt) : rec_addr;

  ssw_addr_fifo #(.W(AW), .DEPTH(NCELL)) u_pool (
    .clk(clk), .rst(rst),
    .push(pool_push), .din(pool_din),
    .pop(accept), .dout(pool_dout),
    .empty(pool_empty), .full(pool_full)
  );

  // per-output pointer queues
  logic [NPORT-1:0] q_push, q_empty, q_full, gnt;
  logic [AW-1:0]    q_head [NPORT];
  logic [NPORT-1:0] sel_dest;
  logic [DW-1:0]    sel_data;
  logic             can_take;

  assign sel_dest = dst_a[slot];
  assign sel_data = din_a[slot];
  assign can_take = !filling && !pool_empty && !(|q_full);
  assign accept   = can_take && in_valid[slot];

  for (genvar i = 0; i < NPORT; i++) begin : g_ready
    assign in_ready[i] = can_take && (slot == SW'(i));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_queue
    assign q_push[o] = accept && sel_dest[o];
    ssw_addr_fifo #(.W(AW), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst(rst),
      .push(q_push[o]), .din(pool_dout),
      .pop(gnt[o]), .dout(q_head[o]),
      .empty(q_empty[o]), .full(q_full[o])
    );
  end

  // output read slot
  logic [SW-1:0] gnt_idx;
  logic          rd_fire;
  logic [AW-1:0] raddr;

  ssw_rr_arb #(.N(NPORT)) u_arb (
    .clk(clk), .rst(rst),
    .req(~q_empty), .gnt(gnt), .gnt_idx(gnt_idx), .any(rd_fire)
  );

  assign raddr = q_head[gnt_idx];

  // shared cell memory: its addressing is the switch
  logic [DW-1:0] rd_q;
  ssw_cell_ram #(.DW(DW), .NCELL(NCELL)) u_ram (
    .clk(clk), .we(accept), .waddr(pool_dout), .wdata(sel_data),
    .raddr(raddr), .rdata(rd_q)
  );

  // reader counts per location
  logic [RCW-1:0] refcnt [NCELL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NCELL; a++) refcnt[a] <= '0;
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      out_valid <= '0;
    end else begin
      if (accept)  refcnt[pool_dout] <= RCW'($countones(sel_dest));
      if (rd_fire) refcnt[raddr]     <= refcnt[raddr] - 1'b1;
      rec_valid <= rd_fire && (refcnt[raddr] == RCW'(1));
      rec_addr  <= raddr;
      out_valid <= gnt;
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign out_data[o*DW +: DW] = rd_q;
  end

  // R1: nothing enters or leaves while the pool loads
  p_quiet_fill_r1: assert property (@(posedge clk) disable iff (rst)
    filling |=> (out_valid == '0));

  // R2: a single input is admitted per cycle
  p_one_ready_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  // R5: an admitted cell names at least one output (input assumption)
  p_dest_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    accept |-> (sel_dest != '0));

  // R6: one cell read per cycle
  p_one_read_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  // R9: only live locations are read, and recycling never overfills the pool
  p_live_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> (refcnt[raddr] != '0));

  p_recycle_room_r9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !pool_full);

endmodule

// File: tb/sim_shared_cell_switch.sv
module sim_shared_cell_switch;

  localparam int CLK_PERIOD = 10;
  localparam int S      = 4;
  localparam int DW     = 256;
  localparam int NCELL  = 16;
  localparam int QDEPTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [S-1:0]     in_valid = '0;
  logic [S*DW-1:0]  in_data  = '0;
  logic [S*S-1:0]   in_dest  = '0;
  logic [S-1:0]     in_ready, out_valid;
  logic [S*DW-1:0]  out_data;

  shared_cell_switch #(.NPORT(S), .DW(DW), .NCELL(NCELL), .QDEPTH(QDEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_dest(in_dest), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] expq [S][$];
  int sent_cnt [S];
  int got_cnt  [S];
  bit run_mon = 0, bc_phase = 0, rot_armed = 0;
  int last_idx = 0, bp_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_bit(input logic [S-1:0] v);
    for (int i = 0; i < S; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] mk(input int p, input int n);
    logic [31:0] w;
    w = {8'(p), 24'(n)};
    return {(DW/32){w}};
  endfunction

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(input int p, input logic [S-1:0] d, input logic [DW-1:0] v);
    in_valid[p] = 1'b1;
    in_data[p*DW +: DW] = v;
    in_dest[p*S +: S] = d;
    while (!in_ready[p]) @(negedge clk);
    for (int o = 0; o < S; o++) if (d[o]) begin
      expq[o].push_back(v);
      sent_cnt[o]++;
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      bit all_empty = 1;
      for (int o = 0; o < S; o++) if (expq[o].size() != 0) all_empty = 0;
      if (all_empty) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (run_mon) begin
      chk($onehot0(out_valid), "R6 single read", DW'(out_valid), '0);
      chk($onehot0(in_ready), "R2 single ready", DW'(in_ready), '0);
      if (bc_phase && in_ready == '0) bp_seen++;
      if (out_valid != '0) begin
        int idx;
        idx = first_bit(out_valid);
        if (expq[idx].size() == 0)
          chk(0, "R3 spurious cell", out_data[idx*DW +: DW], '0);
        else begin
          logic [DW-1:0] e;
          e = expq[idx].pop_front();
          got_cnt[idx]++;
          chk(out_data[idx*DW +: DW] == e, "R4 order and data",
              out_data[idx*DW +: DW], e);
        end
        if (bc_phase && rot_armed)
          chk(idx == (last_idx + 1) % S, "R7 rotation", DW'(idx), DW'((last_idx + 1) % S));
        last_idx = idx;
        if (bc_phase) rot_armed = 1;
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int n;
    int base;
    for (int o = 0; o < S; o++) begin sent_cnt[o] = 0; got_cnt[o] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: quiet load phase, ready after exactly NCELL edges, on input 0
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (in_ready == '0) chk(out_valid == '0, "R1 quiet outputs", DW'(out_valid), '0);
    end while (in_ready == '0 && n < 100);
    chk(n == NCELL, "R1 load length", DW'(n), DW'(NCELL));
    chk(in_ready == 1, "R2 first slot", DW'(in_ready), 1);
    run_mon = 1;

    // R2: idle rotation of the admission slot
    base = first_bit(in_ready);
    for (int k = 0; k < 2*S; k++) begin
      @(negedge clk);
      chk($onehot(in_ready), "R2 ready present", DW'(in_ready), '0);
      chk(first_bit(in_ready) == (base + 1) % S, "R2 slot order",
          DW'(first_bit(in_ready)), DW'((base + 1) % S));
      base = first_bit(in_ready);
    end

    // R3: unicast, each input to a neighbour output
    for (int p = 0; p < S; p++) send(p, S'(1 << ((p + 1) % S)), mk(p, 100 + p));
    drain();

    // R4: all inputs converge on output 2, several cells each
    fork
      begin for (int j = 0; j < 3; j++) send(0, S'(4), mk(0, 200 + j)); end
      begin for (int j = 0; j < 3; j++) send(1, S'(4), mk(1, 210 + j)); end
      begin for (int j = 0; j < 3; j++) send(2, S'(4), mk(2, 220 + j)); end
      begin for (int j = 0; j < 3; j++) send(3, S'(4), mk(3, 230 + j)); end
    join
    drain();

    // R5: multicast masks
    send(1, S'(4'b0101), mk(1, 300));
    send(3, S'(4'b1110), mk(3, 301));
    send(0, S'(4'b1111), mk(0, 302));
    drain();

    // R7 and R8: broadcast load from all inputs
    bc_phase = 1;
    rot_armed = 0;
    fork
      begin for (int j = 0; j < 6; j++) send(0, '1, mk(0, 400 + j)); end
      begin for (int j = 0; j < 6; j++) send(1, '1, mk(1, 410 + j)); end
      begin for (int j = 0; j < 6; j++) send(2, '1, mk(2, 420 + j)); end
      begin for (int j = 0; j < 6; j++) send(3, '1, mk(3, 430 + j)); end
    join
    drain();
    bc_phase = 0;
    chk(bp_seen > 0, "R8 stall observed", DW'(bp_seen), 1);

    // R9: mixed traffic far beyond NCELL cells
    fork
      begin for (int j = 0; j < 30; j++) send(0, S'($urandom_range(1, (1 << S) - 1)), mk(0, 500 + j)); end
      begin for (int j = 0; j < 30; j++) send(1, S'($urandom_range(1, (1 << S) - 1)), mk(1, 600 + j)); end
      begin for (int j = 0; j < 30; j++) send(2, S'($urandom_range(1, (1 << S) - 1)), mk(2, 700 + j)); end
      begin for (int j = 0; j < 30; j++) send(3, S'($urandom_range(1, (1 << S) - 1)), mk(3, 800 + j)); end
    join
    drain();

    for (int o = 0; o < S; o++) begin
      chk(expq[o].size() == 0, "R9 all delivered", DW'(expq[o].size()), '0);
      chk(got_cnt[o] == sent_cnt[o], "R5 per-output count", DW'(got_cnt[o]), DW'(sent_cnt[o]));
    end
    // R9: pool fully recovered, so admission is open again
    @(negedge clk);
    chk(in_ready != '0, "R9 pool recovered", DW'(in_ready), 1);
    finish_up();
  end

endmodule